// File: doc/BRIEF.md
# Multi-Locality Access Arbiter

This block decides which of several requesters, called localities, may use a shared command interface at any moment. Each locality sees its own byte-wide access register, placed at the bottom of its own 4 KiB window of the address map, so a requester reaches it by putting its locality number in the upper address bits. A requester asks for the interface by writing a request bit and gives it up by writing a relinquish bit. The arbiter hands the interface to one locality at a time and tells the current owner when someone else is waiting.

Until the device signals that initialization has finished, the registers read as zero and all writes are dropped. Once a valid flag is set, the owner and the pending requests can be seen by reading the registers. Whenever the owner changes, the block sends a one-cycle pulse to the interrupt logic, and it also presents the current owner as plain outputs. Reads are combinational from the address while `rd_en` is high. Writes take effect at the clock edge that samples `wr_en`.

Top module: `loc_access_arbiter`

## Requirements
- R1: Bit 7 (valid) of every access register reads 0 after reset until `init_done` has been high at a clock edge, and from then on it reads 1 until the next reset, even if `init_done` falls again. While valid is 0, every register reads 0x00 and no locality owns the interface.
- R2: Writes made while valid is 0 have no effect: no request is remembered and no ownership is granted later because of them.
- R3: The access register of locality l is at address `l << 12` (addr[14:12] = l, addr[11:0] = 0), for l from 0 to 4. Any other offset, and locality numbers 5 to 7, read 0x00, and writes there change nothing.
- R4: Writing a byte with bit 1 set to a locality's register records a request at that write's clock edge. If the interface is free, ownership goes to that locality on the next edge, and then `owner_valid` = 1, `owner_id` = l, and bit 5 of register l reads 1.
- R5: When the interface is free and several requests are outstanding, the highest-numbered locality gets ownership on the next edge, and the others stay pending.
- R6: Bit 2 reads 1 in the owner's register only while at least one other locality has an outstanding request. It reads 0 in every register that does not belong to the owner.
- R7: A write with bit 5 set to the owner's register frees the interface at that edge (`owner_valid` = 0, `owner_id` = 0). If requests are pending, the next grant follows one edge later.
- R8: A relinquish write from a locality that is not the owner is ignored. A request write from the current owner records nothing, so the owner's bit 1 and bit 2 stay unchanged.
- R9: `loc_change` is high for exactly the one cycle that follows each edge at which the owner state (`owner_valid`, `owner_id`) changes. This covers both grants and releases.
- R10: Bit 1 reads 1 while that locality's request is outstanding and clears when that locality is granted. Bits 0, 3, 4 and 6 always read 0, and writing them has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_done | input | 1 | Device initialization complete; sets the sticky valid flag |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| rd_en | input | 1 | Read strobe; enables `rdata` |
| addr | input | 15 | Byte address: locality in [14:12], offset in [11:0] |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte; 0 when `rd_en` is low or no register is addressed |
| owner_valid | output | 1 | A locality currently owns the interface |
| owner_id | output | 3 | Number of the owning locality; 0 when free |
| loc_change | output | 1 | One-cycle pulse after every change of owner |

## Verification
The hardest case to reach is priority resolution, because a request made while the interface is free is granted on the very next edge, before a competing request can arrive. The stimulus therefore keeps the interface owned while it loads requests from several lower- and higher-numbered localities. It then checks the owner's pending bit and the waiters' request bits. Finally it releases ownership step by step, which makes the arbiter choose among the waiters several times in a row, and it checks each choice and each change pulse at the edge where it must appear.

// File: rtl/locarb_pkg.sv
package locarb_pkg;

    localparam int LOC_COUNT_DEF = 5;
    localparam int WIN_BITS_DEF  = 12;

    // bit positions the software side decodes
    localparam int POS_VALID   = 7;
    localparam int POS_ACTIVE  = 5;
    localparam int POS_PENDING = 2;
    localparam int POS_ASK     = 1;

    // intent carried by one written byte
    typedef struct packed {
        logic ask;
        logic give_up;
    } wr_cmd_t;

    // what one locality's register shows on a read
    typedef struct packed {
        logic valid;
        logic active;
        logic pending;
        logic asking;
    } acc_view_t;

    function automatic wr_cmd_t decode_wr(input logic [7:0] b);
        wr_cmd_t c;
        c.ask     = b[POS_ASK];
        c.give_up = b[POS_ACTIVE];
        return c;
    endfunction

    function automatic logic [7:0] pack_access(input acc_view_t v);
        logic [7:0] b;
        b              = 8'h00;
        b[POS_VALID]   = v.valid;
        b[POS_ACTIVE]  = v.active;
        b[POS_PENDING] = v.pending;
        b[POS_ASK]     = v.asking;
        return b;
    endfunction

endpackage

// File: rtl/locarb_decode.sv
module locarb_decode
    import locarb_pkg::*;
#(
    parameter int NUM_LOC  = LOC_COUNT_DEF,
    parameter int WIN_BITS = WIN_BITS_DEF,
    parameter int LOC_W    = $clog2(NUM_LOC),
    parameter int ADDR_W   = WIN_BITS + LOC_W
) (
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic                valid,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [7:0]          wdata,
    output logic [LOC_W-1:0]    sel_loc,
    output logic                rd_hit,
    output logic [NUM_LOC-1:0]  req_wr,
    output logic [NUM_LOC-1:0]  rel_wr
);

    logic    in_window;
    logic    reg_hit;
    wr_cmd_t cmd;

    assign sel_loc   = addr[ADDR_W-1:WIN_BITS];
    assign in_window = (addr[WIN_BITS-1:0] == '0);
    assign reg_hit   = in_window && (int'(sel_loc) < NUM_LOC);
    assign cmd       = decode_wr(wdata);
    assign rd_hit    = rd_en && valid && reg_hit;

    for (genvar g = 0; g < NUM_LOC; g++) begin : g_strobe
        logic match;
        assign match     = reg_hit && (sel_loc == LOC_W'(g));
        assign req_wr[g] = wr_en && valid && match && cmd.ask;
        assign rel_wr[g] = wr_en && valid && match && cmd.give_up;
    end

endmodule

// File: rtl/locarb_req_track.sv
module locarb_req_track #(
    parameter int NUM_LOC = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_LOC-1:0] req_wr,
    input  logic [NUM_LOC-1:0] owner_oh,
    input  logic [NUM_LOC-1:0] grant_oh,
    output logic [NUM_LOC-1:0] req_q
);

    for (genvar g = 0; g < NUM_LOC; g++) begin : g_req
        always_ff @(posedge clk) begin
            if (rst) begin
                req_q[g] <= 1'b0;
            end else if (grant_oh[g]) begin
                req_q[g] <= 1'b0;
            end else if (req_wr[g] && !owner_oh[g]) begin
                req_q[g] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/locarb_grant.sv
module locarb_grant #(
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = $clog2(NUM_LOC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_LOC-1:0] req_q,
    input  logic [NUM_LOC-1:0] rel_wr,
    output logic               owner_valid,
    output logic [LOC_W-1:0]   owner_id,
    output logic [NUM_LOC-1:0] owner_oh,
    output logic [NUM_LOC-1:0] grant_oh,
    output logic               loc_change
);

    typedef struct packed {
        logic             held;
        logic [LOC_W-1:0] id;
    } own_t;

    own_t             cur, nxt;
    logic [LOC_W-1:0] win_id;
    logic             any_req;
    logic             releasing;

    // ascending scan: the last set bit, i.e. the highest locality, wins
    always_comb begin
        win_id  = '0;
        any_req = 1'b0;
        for (int i = 0; i < NUM_LOC; i++) begin
            if (req_q[i]) begin
                win_id  = LOC_W'(i);
                any_req = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < NUM_LOC; g++) begin : g_own
        assign owner_oh[g] = cur.held && (cur.id == LOC_W'(g));
    end

    assign releasing = |(rel_wr & owner_oh);

    always_comb begin
        nxt      = cur;
        grant_oh = '0;
        if (releasing) begin
            nxt.held = 1'b0;
            nxt.id   = '0;
        end else if (!cur.held && any_req) begin
            nxt.held = 1'b1;
            nxt.id   = win_id;
            grant_oh = NUM_LOC'(1) << win_id;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur        <= '0;
            loc_change <= 1'b0;
        end else begin
            cur        <= nxt;
            loc_change <= (nxt != cur);
        end
    end

    assign owner_valid = cur.held;
    assign owner_id    = cur.id;

endmodule

// File: rtl/locarb_readback.sv
module locarb_readback
    import locarb_pkg::*;
#(
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = $clog2(NUM_LOC)
) (
    input  logic               valid,
    input  logic               rd_hit,
    input  logic [LOC_W-1:0]   sel_loc,
    input  logic [NUM_LOC-1:0] req_q,
    input  logic [NUM_LOC-1:0] owner_oh,
    output logic [7:0]         rdata
);

    logic [7:0] view_b [NUM_LOC];

    for (genvar g = 0; g < NUM_LOC; g++) begin : g_view
        logic [NUM_LOC-1:0] others;
        acc_view_t          v;
        assign others    = req_q & ~(NUM_LOC'(1) << g);
        assign v.valid   = valid;
        assign v.active  = owner_oh[g];
        assign v.pending = owner_oh[g] && (|others);
        assign v.asking  = req_q[g];
        assign view_b[g] = pack_access(v);
    end

    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < NUM_LOC; i++) begin
            if (rd_hit && (sel_loc == LOC_W'(i))) begin
                rdata = view_b[i];
            end
        end
    end

endmodule

// File: rtl/loc_access_arbiter.sv
module loc_access_arbiter
    import locarb_pkg::*;
#(
    parameter int NUM_LOC  = LOC_COUNT_DEF,
    parameter int WIN_BITS = WIN_BITS_DEF,
    parameter int LOC_W    = $clog2(NUM_LOC),
    parameter int ADDR_W   = WIN_BITS + LOC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_done,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              owner_valid,
    output logic [LOC_W-1:0]  owner_id,
    output logic              loc_change
);

    logic               valid_q;
    logic [LOC_W-1:0]   sel_loc;
    logic               rd_hit;
    logic [NUM_LOC-1:0] req_wr;
    logic [NUM_LOC-1:0] rel_wr;
    logic [NUM_LOC-1:0] req_q;
    logic [NUM_LOC-1:0] owner_oh;
    logic [NUM_LOC-1:0] grant_oh;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
        end else if (init_done) begin
            valid_q <= 1'b1;
        end
    end

    locarb_decode #(
        .NUM_LOC(NUM_LOC), .WIN_BITS(WIN_BITS), .LOC_W(LOC_W), .ADDR_W(ADDR_W)
    ) u_decode (
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .valid  (valid_q),
        .addr   (addr),
        .wdata  (wdata),
        .sel_loc(sel_loc),
        .rd_hit (rd_hit),
        .req_wr (req_wr),
        .rel_wr (rel_wr)
    );

    locarb_req_track #(.NUM_LOC(NUM_LOC)) u_track (
        .clk     (clk),
        .rst     (rst),
        .req_wr  (req_wr),
        .owner_oh(owner_oh),
        .grant_oh(grant_oh),
        .req_q   (req_q)
    );

    locarb_grant #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_grant (
        .clk        (clk),
        .rst        (rst),
        .req_q      (req_q),
        .rel_wr     (rel_wr),
        .owner_valid(owner_valid),
        .owner_id   (owner_id),
        .owner_oh   (owner_oh),
        .grant_oh   (grant_oh),
        .loc_change (loc_change)
    );

    locarb_readback #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_read (
        .valid   (valid_q),
        .rd_hit  (rd_hit),
        .sel_loc (sel_loc),
        .req_q   (req_q),
        .owner_oh(owner_oh),
        .rdata   (rdata)
    );

endmodule

// File: rtl/locarb_checker.sv
module locarb_checker #(
    parameter int NUM_LOC  = 5,
    parameter int WIN_BITS = 12,
    parameter int LOC_W    = 3,
    parameter int ADDR_W   = 15
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [7:0]         wdata,
    input logic               valid_q,
    input logic [NUM_LOC-1:0] req_q,
    input logic               owner_valid,
    input logic [LOC_W-1:0]   owner_id,
    input logic               loc_change
);

    logic [LOC_W-1:0] exp_win;
    logic             own_req;
    logic             rel_hit;

    always_comb begin
        exp_win = '0;
        own_req = 1'b0;
        for (int i = 0; i < NUM_LOC; i++) begin
            if (req_q[i]) exp_win = LOC_W'(i);
            if (req_q[i] && owner_valid && owner_id == LOC_W'(i)) own_req = 1'b1;
        end
    end

    assign rel_hit = (addr[WIN_BITS-1:0] == '0) && (addr[ADDR_W-1:WIN_BITS] == owner_id);

    a_r1_owner_needs_valid: assert property (@(posedge clk) disable iff (rst)
        !valid_q |-> !owner_valid);

    a_r2_no_req_before_valid: assert property (@(posedge clk) disable iff (rst)
        !valid_q |-> (req_q == '0));

    a_r5_grant_highest: assert property (@(posedge clk) disable iff (rst)
        (!owner_valid && (req_q != '0)) |=> (owner_valid && owner_id == $past(exp_win)));

    a_r7_release_frees: assert property (@(posedge clk) disable iff (rst)
        (wr_en && owner_valid && rel_hit && wdata[5]) |=> !owner_valid);

    a_r8_owner_not_queued: assert property (@(posedge clk) disable iff (rst)
        !own_req);

    a_r9_change_pulses: assert property (@(posedge clk) disable iff (rst)
        !$stable({owner_valid, owner_id}) |-> loc_change);

    a_r9_pulse_has_cause: assert property (@(posedge clk) disable iff (rst)
        loc_change |-> !$stable({owner_valid, owner_id}));

endmodule

bind loc_access_arbiter locarb_checker #(
    .NUM_LOC(NUM_LOC), .WIN_BITS(WIN_BITS), .LOC_W(LOC_W), .ADDR_W(ADDR_W)
) i_checker (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .valid_q    (valid_q),
    .req_q      (req_q),
    .owner_valid(owner_valid),
    .owner_id   (owner_id),
    .loc_change (loc_change)
);

// File: tb/test_loc_access_arbiter.sv
`timescale 1ns/1ps
module test_loc_access_arbiter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        init_done = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [14:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        owner_valid;
    logic [2:0]  owner_id;
    logic        loc_change;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    loc_access_arbiter i_loc_access_arbiter (
        .clk(clk), .rst(rst), .init_done(init_done), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .owner_valid(owner_valid),
        .owner_id(owner_id), .loc_change(loc_change)
    );

    function automatic logic [7:0] acc(input bit v, input bit act, input bit pend, input bit ask);
        return {v, 1'b0, act, 2'b00, pend, ask, 1'b0};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input int loc, input logic [11:0] off, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = {loc[2:0], off};
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        wdata = 8'h00;
    endtask

    task automatic rd(input int loc, input logic [11:0] off, output logic [7:0] d);
        rd_en = 1'b1;
        addr  = {loc[2:0], off};
        #1;
        d     = rdata;
        rd_en = 1'b0;
        #0.5;
    endtask

    task automatic owner_is(input string req, input bit v, input int id, input bit pulse);
        chk({req, " owner_valid"}, 32'(owner_valid), 32'(v));
        chk({req, " owner_id"}, 32'(owner_id), 32'(id));
        chk({req, " loc_change"}, 32'(loc_change), 32'(pulse));
    endtask

    task automatic t_reset();
        logic [7:0] d;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        rd(0, 12'h000, d);
        chk("R1 reset read", 32'(d), 32'h00);
        owner_is("R1 reset", 1'b0, 0, 1'b0);
    endtask

    task automatic t_before_init();
        logic [7:0] d;
        wr(3, 12'h000, 8'h02);
        tick(); tick();
        owner_is("R2 write before valid", 1'b0, 0, 1'b0);
        rd(3, 12'h000, d);
        chk("R1 R2 read before valid", 32'(d), 32'h00);
        init_done = 1'b1;
        tick();
        init_done = 1'b0;
        tick(); tick();
        rd(0, 12'h000, d);
        chk("R1 valid sticky", 32'(d), 32'(acc(1, 0, 0, 0)));
        rd(3, 12'h000, d);
        chk("R2 no stale request", 32'(d), 32'(acc(1, 0, 0, 0)));
        owner_is("R2 no late grant", 1'b0, 0, 1'b0);
    endtask

    task automatic t_single_grant();
        logic [7:0] d;
        wr(1, 12'h000, 8'h02);
        owner_is("R4 not yet granted", 1'b0, 0, 1'b0);
        rd(1, 12'h000, d);
        chk("R10 request bit visible", 32'(d), 32'(acc(1, 0, 0, 1)));
        tick();
        owner_is("R4 R9 granted", 1'b1, 1, 1'b1);
        rd(1, 12'h000, d);
        chk("R4 R10 owner reads active", 32'(d), 32'(acc(1, 1, 0, 0)));
        tick();
        chk("R9 pulse one cycle", 32'(loc_change), 32'h0);
        rd(0, 12'h000, d);
        chk("R4 non-owner inactive", 32'(d), 32'(acc(1, 0, 0, 0)));
    endtask

    task automatic t_ignored();
        logic [7:0] d;
        wr(2, 12'h000, 8'h20);
        tick();
        owner_is("R8 foreign relinquish", 1'b1, 1, 1'b0);
        wr(1, 12'h000, 8'h02);
        tick();
        rd(1, 12'h000, d);
        chk("R8 owner request no effect", 32'(d), 32'(acc(1, 1, 0, 0)));
        owner_is("R8 owner unchanged", 1'b1, 1, 1'b0);
    endtask

    task automatic t_priority();
        logic [7:0] d;
        wr(2, 12'h000, 8'h02);
        wr(4, 12'h000, 8'h02);
        wr(0, 12'h000, 8'h02);
        rd(1, 12'h000, d);
        chk("R6 owner sees pending", 32'(d), 32'(acc(1, 1, 1, 0)));
        rd(4, 12'h000, d);
        chk("R6 R10 waiter view", 32'(d), 32'(acc(1, 0, 0, 1)));
        wr(1, 12'h000, 8'h20);
        owner_is("R7 R9 release", 1'b0, 0, 1'b1);
        tick();
        owner_is("R5 highest wins", 1'b1, 4, 1'b1);
        rd(4, 12'h000, d);
        chk("R6 new owner pending", 32'(d), 32'(acc(1, 1, 1, 0)));
        rd(2, 12'h000, d);
        chk("R5 loser stays pending", 32'(d), 32'(acc(1, 0, 0, 1)));
        wr(4, 12'h000, 8'h20);
        tick();
        owner_is("R5 next highest", 1'b1, 2, 1'b1);
        wr(2, 12'h000, 8'h20);
        tick();
        owner_is("R5 last waiter", 1'b1, 0, 1'b1);
        rd(0, 12'h000, d);
        chk("R6 nobody waiting", 32'(d), 32'(acc(1, 1, 0, 0)));
        wr(0, 12'h000, 8'h20);
        owner_is("R7 free", 1'b0, 0, 1'b1);
        tick();
        owner_is("R7 stays free", 1'b0, 0, 1'b0);
    endtask

    task automatic t_decode();
        logic [7:0] d;
        wr(5, 12'h000, 8'h02);
        wr(7, 12'h000, 8'h02);
        wr(2, 12'h018, 8'h02);
        tick(); tick();
        owner_is("R3 writes outside registers", 1'b0, 0, 1'b0);
        rd(5, 12'h000, d);
        chk("R3 locality 5 reads 0", 32'(d), 32'h00);
        rd(2, 12'h004, d);
        chk("R3 other offset reads 0", 32'(d), 32'h00);
        rd(2, 12'h000, d);
        chk("R3 no stray request", 32'(d), 32'(acc(1, 0, 0, 0)));
    endtask

    task automatic t_reserved();
        logic [7:0] d;
        wr(3, 12'h000, 8'hFF);
        tick();
        owner_is("R10 all-ones write grants", 1'b1, 3, 1'b1);
        rd(3, 12'h000, d);
        chk("R10 reserved bits read 0", 32'(d), 32'(acc(1, 1, 0, 0)));
        wr(3, 12'h000, 8'hDD);
        tick();
        owner_is("R10 read-only bits ignored", 1'b1, 3, 1'b0);
        rd(3, 12'h000, d);
        chk("R10 register unchanged", 32'(d), 32'(acc(1, 1, 0, 0)));
        wr(3, 12'h000, 8'h20);
        owner_is("R7 final release", 1'b0, 0, 1'b1);
    endtask

    initial begin
        t_reset();
        t_before_init();
        t_single_grant();
        t_ignored();
        t_priority();
        t_decode();
        t_reserved();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule